// File: doc/BRIEF.md
# SPI Master Shift Engine with Programmable Frame Gap

This block is the serial core of an SPI master. It takes transmit words over a valid/ready handshake and shifts them out most significant bit first on `mosi`. At the same time it shifts the word arriving on `miso` into a receive register. A frame is 8 or 16 bits long. The serial clock runs at a fixed quarter of the master clock. Its idle level is selectable, and within each bit outgoing data moves on the edge leaving idle while incoming data is captured on the edge returning to idle.

A gap setting of 8 bits can hold the serial clock idle for a set number of master clocks after every frame, in steps of four. A gap of zero lets frames stream back to back whenever the next word is offered in time. When no word is waiting at the end of a frame, after any gap, the engine stops and drops `busy` without producing extra clocks. Polarity, frame size and gap are sampled once, when a word is accepted, so a change made during a frame only applies to the next one.

Top module: `spi_gap_master`

## Requirements
- R1: After reset `busy` and `rx_valid` are 0, `tx_ready` is 1 and `sclk` equals `cfg_cpol`.
- R2: While not busy, `sclk` sits at `cfg_cpol`: low for 0, high for 1.
- R3: Transmit bits leave MSB first, and `mosi` changes only on an `sclk` edge that leaves the idle level.
- R4: `miso` is captured on each edge that returns `sclk` to idle (falling for polarity 0, rising for polarity 1), and the first captured bit becomes the MSB of the received word.
- R5: `cfg_wide`=1 selects 16-bit frames and `cfg_wide`=0 selects 8-bit frames. A frame has exactly that many `sclk` cycles, and 8-bit frames send `tx_data[7:0]`.
- R6: Each frame yields exactly one `rx_valid` pulse, one cycle long, raised only while busy. In 8-bit mode `rx_data[15:8]` is 0.
- R7: Each serial bit lasts four master clocks: two with `sclk` away from idle, then two at idle.
- R8: After a frame with a non-zero gap value G, `sclk` stays idle for 4*G master clocks beyond the normal bit time, so the idle span between the last capture edge and the next frame's first edge is 2+4*G clocks. `sclk` is at the frame's idle level throughout the gap.
- R9: With G=0 and a word waiting, the next frame follows with the ordinary 2-clock idle span.
- R10: With no word waiting at the end of a frame (after any gap), the block drops `busy`, raises `tx_ready` and produces no further `sclk` edges.
- R11: Polarity, frame size and gap value are latched when a word is accepted. Changes made during a frame do not alter that frame.
- R12: `tx_ready` is high only while idle, in the last cycle of a gap-free frame, or in the last gap cycle. It is low in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_wide | input | 1 | 1: 16-bit frames, 0: 8-bit frames |
| cfg_gap | input | 8 | Dead time after each frame, in units of four master clocks |
| tx_data | input | 16 | Word to transmit |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Engine accepts the offered word this cycle |
| rx_data | output | 16 | Received word, zero-extended in 8-bit mode |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| busy | output | 1 | A frame or gap is in progress |

## Verification
The assertions check several properties on every cycle. The idle clock level follows `cfg_cpol` when not busy, and `sclk` holds the latched idle level during a gap. `mosi` stays still except where the clock leaves idle or a new word loads. `tx_ready` is always high when idle, and `rx_valid` is a lone pulse raised only while busy. The bench scenarios cover what only whole transfers can show. A model slave checks the bit order and capture edge in both polarities, and it also checks the frame length in both sizes. The scenarios measure the idle span between frames for zero and non-zero gaps. They also show that configuration changes made mid-frame wait for the next frame, and that no clocks follow the last word.

// File: rtl/sgm_pkg.sv
`timescale 1ns/1ps
package sgm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } sgm_state_e;
endpackage

// File: rtl/sgm_phase_gen.sv
`timescale 1ns/1ps
// Divides one serial bit into DIV master clocks: first half away from idle,
// second half at idle.
module sgm_phase_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic ph_act,
   output logic ph_cap,
   output logic ph_last
);
   localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);
   localparam logic [PH_W-1:0] PH_CAP  = PH_W'(DIV / 2 - 1);
   localparam logic [PH_W-1:0] PH_END  = PH_W'(DIV - 1);

   logic [PH_W-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          ph_q <= '0;
      else if (!run)       ph_q <= '0;
      else if (ph_q == PH_END) ph_q <= '0;
      else                 ph_q <= ph_q + 1'b1;
   end

   assign ph_act  = (ph_q < PH_HALF);
   assign ph_cap  = (ph_q == PH_CAP);
   assign ph_last = (ph_q == PH_END);
endmodule

// File: rtl/sgm_shift_pair.sv
`timescale 1ns/1ps
// Transmit and receive shift registers; narrow words ride left-aligned.
module sgm_shift_pair #(
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_wide,
   input  logic [WORD_W-1:0] tx_word,
   input  logic              shift,
   input  logic              cap,
   input  logic              cap_last,
   input  logic              wide,
   input  logic              miso,
   output logic              mosi,
   output logic [WORD_W-1:0] rx_word,
   output logic              rx_stb
);
   logic [WORD_W-1:0] tx_sh_q;
   logic [WORD_W-1:0] rx_sh_q;
   logic [WORD_W-1:0] rx_next;
   logic [WORD_W-1:0] load_val;
   logic [WORD_W-1:0] rx_fmt;

   assign rx_next = {rx_sh_q[WORD_W-2:0], miso};

   generate
      if (WORD_W > NARROW_W) begin : g_two_sizes
         localparam int PAD = WORD_W - NARROW_W;
         assign load_val = load_wide ? tx_word
                                     : {tx_word[NARROW_W-1:0], {PAD{1'b0}}};
         assign rx_fmt   = wide ? rx_next
                                : {{PAD{1'b0}}, rx_next[NARROW_W-1:0]};
      end else begin : g_one_size
         assign load_val = tx_word;
         assign rx_fmt   = rx_next;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sh_q <= '0;
         rx_sh_q <= '0;
         rx_word <= '0;
         rx_stb  <= 1'b0;
      end else begin
         rx_stb <= 1'b0;
         if (load)       tx_sh_q <= load_val;
         else if (shift) tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
         if (load)       rx_sh_q <= '0;
         else if (cap)   rx_sh_q <= rx_next;
         if (cap && cap_last) begin
            rx_word <= rx_fmt;
            rx_stb  <= 1'b1;
         end
      end
   end

   assign mosi = tx_sh_q[WORD_W-1];
endmodule

// File: rtl/sgm_gap_timer.sv
`timescale 1ns/1ps
// Counts the dead time after a frame: gap_val * DIV master clocks.
module sgm_gap_timer #(
   parameter int GAP_W = 8,
   parameter int DIV   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [GAP_W-1:0] gap_val,
   output logic             gap_last
);
   localparam int CNT_W = GAP_W + $clog2(DIV) + 1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= CNT_W'(gap_val) * CNT_W'(DIV);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign gap_last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/spi_gap_master.sv
`timescale 1ns/1ps
module spi_gap_master
   import sgm_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int NARROW_W = 8,
   parameter int GAP_W    = 8,
   parameter int DIV      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_cpol,
   input  logic              cfg_wide,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic [WORD_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   output logic [WORD_W-1:0] rx_data,
   output logic              rx_valid,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic              busy
);
   localparam int BIT_W = $clog2(WORD_W);
   localparam logic [BIT_W-1:0] LAST_WIDE   = BIT_W'(WORD_W - 1);
   localparam logic [BIT_W-1:0] LAST_NARROW = BIT_W'(NARROW_W - 1);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("spi_gap_master: DIV must be even and at least 2");
      end
      if (WORD_W < 2 || NARROW_W < 1 || NARROW_W > WORD_W) begin : g_bad_width
         $error("spi_gap_master: need 1 <= NARROW_W <= WORD_W and WORD_W >= 2");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("spi_gap_master: GAP_W must be at least 1");
      end
   endgenerate

   sgm_state_e       st_q, st_d;
   logic [BIT_W-1:0] bit_q;
   logic             pol_q, wide_q;
   logic [GAP_W-1:0] gap_q;
   logic             ph_act, ph_cap, ph_last;
   logic             gap_last;
   logic             last_bit, frame_end, ld, in_gap;

   sgm_phase_gen #(.DIV(DIV)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st_q == ST_SHIFT),
      .ph_act  (ph_act),
      .ph_cap  (ph_cap),
      .ph_last (ph_last)
   );

   assign last_bit  = (bit_q == (wide_q ? LAST_WIDE : LAST_NARROW));
   assign frame_end = (st_q == ST_SHIFT) && ph_last && last_bit;
   assign in_gap    = (st_q == ST_GAP);

   assign tx_ready = (st_q == ST_IDLE)
                   || (frame_end && (gap_q == '0))
                   || (in_gap && gap_last);
   assign ld = tx_valid && tx_ready;

   sgm_gap_timer #(.GAP_W(GAP_W), .DIV(DIV)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (frame_end && (gap_q != '0)),
      .gap_val  (gap_q),
      .gap_last (gap_last)
   );

   sgm_shift_pair #(.WORD_W(WORD_W), .NARROW_W(NARROW_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ld),
      .load_wide (cfg_wide),
      .tx_word   (tx_data),
      .shift     ((st_q == ST_SHIFT) && ph_last && !last_bit),
      .cap       ((st_q == ST_SHIFT) && ph_cap),
      .cap_last  (last_bit),
      .wide      (wide_q),
      .miso      (miso),
      .mosi      (mosi),
      .rx_word   (rx_data),
      .rx_stb    (rx_valid)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (ld) st_d = ST_SHIFT;
         ST_SHIFT: if (frame_end) begin
                      if (gap_q != '0) st_d = ST_GAP;
                      else             st_d = ld ? ST_SHIFT : ST_IDLE;
                   end
         ST_GAP:   if (gap_last) st_d = ld ? ST_SHIFT : ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         bit_q  <= '0;
         pol_q  <= 1'b0;
         wide_q <= 1'b0;
         gap_q  <= '0;
      end else begin
         st_q <= st_d;
         if (ld) begin
            bit_q  <= '0;
            pol_q  <= cfg_cpol;
            wide_q <= cfg_wide;
            gap_q  <= cfg_gap;
         end else if ((st_q == ST_SHIFT) && ph_last && !last_bit) begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign busy = (st_q != ST_IDLE);
   assign sclk = (st_q == ST_IDLE) ? cfg_cpol
                                   : (pol_q ^ ((st_q == ST_SHIFT) && ph_act));
endmodule

// File: rtl/sgm_checker.sv
`timescale 1ns/1ps
module sgm_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic sclk,
   input logic mosi,
   input logic rx_valid,
   input logic tx_ready,
   input logic cfg_cpol,
   input logic pol_q,
   input logic in_gap,
   input logic ld
);
   // R2: idle clock level follows the polarity input
   a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sclk == cfg_cpol));

   // R3: data out moves only where the clock leaves idle or a word loads
   a_r3_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && $stable(sclk) && !$past(ld)) |-> $stable(mosi));

   // R6: receive strobe is a lone one-cycle pulse
   a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

   // R6: receive strobe only during a transfer
   a_r6_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> busy);

   // R8: clock parked at the latched idle level during the gap
   a_r8_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      in_gap |-> (sclk == pol_q));

   // R10: an idle engine always accepts
   a_r10_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> tx_ready);
endmodule

bind spi_gap_master sgm_checker u_sgm_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .sclk     (sclk),
   .mosi     (mosi),
   .rx_valid (rx_valid),
   .tx_ready (tx_ready),
   .cfg_cpol (cfg_cpol),
   .pol_q    (pol_q),
   .in_gap   (in_gap),
   .ld       (ld)
);

// File: tb/test_spi_gap_master.sv
`timescale 1ns/1ps
module test_spi_gap_master;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_cpol, cfg_wide;
   logic [7:0]  cfg_gap;
   logic [15:0] tx_data;
   logic        tx_valid;
   logic        tx_ready;
   logic [15:0] rx_data;
   logic        rx_valid;
   logic        sclk, mosi, miso, busy;

   int total = 0;
   int bad   = 0;

   spi_gap_master i_spi_gap_master (
      .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_wide(cfg_wide),
      .cfg_gap(cfg_gap), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
      .sclk(sclk), .mosi(mosi), .miso(miso), .busy(busy)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- model slave and monitor (negedge sampling) ----------
   logic        mon_en = 1'b0;
   logic        tb_pol = 1'b0;
   logic        prev_sclk, prev_mosi, prev_busy;
   logic [15:0] s_tx [4];
   logic [15:0] s_rx [4];
   int          s_len [4];
   logic [15:0] s_sh, s_acc;
   int          fidx, sbit, nlead, idle_run, act_run, hi_bad, mosi_bad, rcnt;
   int          spans [64];
   logic [15:0] got_rx [8];

   always @(negedge clk) begin
      if (mon_en) begin
         if (busy && prev_busy && sclk == prev_sclk && mosi !== prev_mosi)
            mosi_bad++;
         if (sclk !== prev_sclk) begin
            if (sclk != tb_pol) begin
               if (nlead < 64) spans[nlead] = idle_run;
               nlead++;
               act_run = 0;
               if (sbit == 0 && fidx < 4)
                  s_sh = (s_len[fidx] == 16) ? s_tx[fidx] : {s_tx[fidx][7:0], 8'h00};
               miso = s_sh[15];
               s_sh = s_sh << 1;
            end else begin
               if (act_run != 2) hi_bad++;
               s_acc = {s_acc[14:0], mosi};
               sbit++;
               if (fidx < 4 && sbit == s_len[fidx]) begin
                  s_rx[fidx] = (s_len[fidx] == 16) ? s_acc : {8'h00, s_acc[7:0]};
                  fidx++;
                  sbit = 0;
               end
               idle_run = 0;
            end
         end
         if (sclk != tb_pol) act_run++;
         else                idle_run++;
         if (rx_valid) begin
            if (rcnt < 8) got_rx[rcnt] = rx_data;
            rcnt++;
         end
      end
      prev_sclk = sclk;
      prev_mosi = mosi;
      prev_busy = busy;
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic mon_start(input logic pol);
      @(negedge clk);
      mon_en   = 1'b0;
      tb_pol   = pol;
      fidx = 0; sbit = 0; nlead = 0; idle_run = 0; act_run = 0;
      hi_bad = 0; mosi_bad = 0; rcnt = 0;
      s_acc = '0; s_sh = '0;
      for (int i = 0; i < 64; i++) spans[i] = -1;
      @(negedge clk);
      mon_en = 1'b1;
   endtask

   task automatic push(input logic [15:0] w);
      tx_data  = w;
      tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_push();
      tx_valid = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic set_cfg(input logic pol, input logic wide, input logic [7:0] gap);
      cfg_cpol = pol;
      cfg_wide = wide;
      cfg_gap  = gap;
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(busy == 1'b0,     "R1 busy after reset", busy, 0);
      chk(rx_valid == 1'b0, "R1 rx_valid after reset", rx_valid, 0);
      chk(tx_ready == 1'b1, "R1 tx_ready after reset", tx_ready, 1);
      chk(sclk == cfg_cpol, "R1 sclk after reset", sclk, cfg_cpol);
   endtask

   task automatic t_frame8();
      set_cfg(1'b0, 1'b0, 8'd0);
      mon_start(1'b0);
      s_tx[0] = 16'h003C; s_len[0] = 8;
      push(16'hFFA5);
      finish_push();
      wait_idle();
      chk(s_rx[0] == 16'h00A5, "R3 8-bit MSB-first out", s_rx[0], 16'h00A5);
      chk(got_rx[0] == 16'h003C, "R4 8-bit capture pol0", got_rx[0], 16'h003C);
      chk(nlead == 8, "R5 8-bit frame clocks", nlead, 8);
      chk(rcnt == 1, "R6 one strobe per frame", rcnt, 1);
      chk(sclk == 1'b0, "R2 idle low", sclk, 0);
      chk(hi_bad == 0, "R7 two active clocks per bit", hi_bad, 0);
      chk(spans[3] == 2, "R7 two idle clocks per bit", spans[3], 2);
      chk(mosi_bad == 0, "R3 mosi moves on leading edge", mosi_bad, 0);
   endtask

   task automatic t_frame16();
      set_cfg(1'b1, 1'b1, 8'd0);
      repeat (2) @(negedge clk);
      chk(sclk == 1'b1, "R2 idle high", sclk, 1);
      mon_start(1'b1);
      s_tx[0] = 16'hBEEF; s_len[0] = 16;
      push(16'h1234);
      finish_push();
      repeat (5) @(negedge clk);
      chk(tx_ready == 1'b0, "R12 not ready mid-frame", tx_ready, 0);
      wait_idle();
      chk(s_rx[0] == 16'h1234, "R3 16-bit MSB-first out", s_rx[0], 16'h1234);
      chk(got_rx[0] == 16'hBEEF, "R4 16-bit capture pol1", got_rx[0], 16'hBEEF);
      chk(nlead == 16, "R5 16-bit frame clocks", nlead, 16);
      chk(hi_bad == 0, "R7 bit timing pol1", hi_bad, 0);
      chk(sclk == 1'b1, "R2 idle high after frame", sclk, 1);
   endtask

   task automatic t_stream();
      int odd;
      set_cfg(1'b0, 1'b0, 8'd0);
      mon_start(1'b0);
      s_tx[0] = 16'h0011; s_tx[1] = 16'h0080; s_tx[2] = 16'h00FE;
      s_len[0] = 8; s_len[1] = 8; s_len[2] = 8;
      push(16'h005A);
      push(16'h00C3);
      push(16'h0001);
      finish_push();
      wait_idle();
      odd = 0;
      for (int i = 1; i < 24; i++) if (spans[i] != 2) odd++;
      chk(odd == 0, "R9 back-to-back spacing", odd, 0);
      chk(nlead == 24, "R9 stream clock count", nlead, 24);
      chk(s_rx[1] == 16'h00C3, "R9 second word out", s_rx[1], 16'h00C3);
      chk(got_rx[2] == 16'h00FE, "R6 third word in", got_rx[2], 16'h00FE);
      chk(rcnt == 3, "R6 strobe count stream", rcnt, 3);
   endtask

   task automatic t_gap();
      set_cfg(1'b0, 1'b0, 8'd3);
      mon_start(1'b0);
      s_tx[0] = 16'h0055; s_tx[1] = 16'h00AA;
      s_len[0] = 8; s_len[1] = 8;
      push(16'h0081);
      push(16'h007E);
      finish_push();
      wait_idle();
      chk(spans[8] == 14, "R8 gap of 3 units", spans[8], 14);
      chk(spans[7] == 2, "R8 in-frame spacing kept", spans[7], 2);
      chk(s_rx[1] == 16'h007E, "R8 word after gap", s_rx[1], 16'h007E);
      chk(got_rx[1] == 16'h00AA, "R8 capture after gap", got_rx[1], 16'h00AA);
   endtask

   task automatic t_cfg_latch();
      set_cfg(1'b0, 1'b1, 8'd0);
      mon_start(1'b0);
      s_tx[0] = 16'h8001; s_tx[1] = 16'h0042;
      s_len[0] = 16; s_len[1] = 8;
      push(16'hC3A5);
      set_cfg(1'b0, 1'b0, 8'd5);
      push(16'hAB96);
      finish_push();
      wait_idle();
      chk(spans[16] == 2, "R11 old gap used for first frame", spans[16], 2);
      chk(nlead == 24, "R11 sizes 16 then 8", nlead, 24);
      chk(s_rx[0] == 16'hC3A5, "R11 first frame intact", s_rx[0], 16'hC3A5);
      chk(got_rx[0] == 16'h8001, "R11 first capture", got_rx[0], 16'h8001);
      chk(got_rx[1] == 16'h0042, "R6 zero-extended narrow word", got_rx[1], 16'h0042);
      chk(s_rx[1] == 16'h0096, "R5 narrow frame sends low byte", s_rx[1], 16'h0096);
   endtask

   task automatic t_no_extra();
      int edges;
      set_cfg(1'b1, 1'b0, 8'd2);
      repeat (2) @(negedge clk);
      mon_start(1'b1);
      s_tx[0] = 16'h0099; s_len[0] = 8;
      push(16'h0066);
      finish_push();
      wait_idle();
      edges = nlead;
      repeat (60) @(negedge clk);
      chk(nlead == edges && edges == 8, "R10 no clocks after last word", nlead, 8);
      chk(busy == 1'b0, "R10 busy drops", busy, 0);
      chk(tx_ready == 1'b1, "R10 ready again", tx_ready, 1);
      chk(got_rx[0] == 16'h0099, "R4 capture pol1 narrow", got_rx[0], 16'h0099);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (WATCHDOG) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // ---------------- main ----------------
   initial begin
      rst_n    = 1'b0;
      miso     = 1'b0;
      tx_valid = 1'b0;
      tx_data  = '0;
      set_cfg(1'b0, 1'b0, 8'd0);
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_frame8();
      t_frame16();
      t_stream();
      t_gap();
      t_cfg_latch();
      t_no_extra();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule